// File: doc/BRIEF.md
# Interleaved-Carrier Three-Phase Multilevel PWM Modulator

This block turns three signed phase references into switch commands for three inverter arms. Each arm is a stack of nested (flying-capacitor) cells, `N_CELLS` of them, and the default is two. Every cell has its own symmetric triangular carrier. The carriers are spread evenly across the switching period, so each cell conducts for an equal share. Seen at the arm output, the ripple runs at `N_CELLS` times the rate of any single switch. For example, a 5 kHz per-switch rate with a 50 Hz fundamental puts the first harmonic cluster near 10 kHz in the three-level case.

Every cell compares its phase reference with its carrier and produces a connection function. That function drives the cell's upper switch directly and its lower switch inverted. Each arm also reports a registered level count: the number of upper switches that are on. The count runs from 0 to `N_CELLS` and selects one of `N_CELLS+1` output voltage steps.

References arrive over a valid/ready stream. `ref_ready` follows `en`, so the stream is back-pressured for as long as modulation is off. A sample is taken on any clock edge where `ref_valid` and `ref_ready` are both high. With no handshake, the previous sample stays in force indefinitely. The carrier half-period comes from a plain control input, and it is read only while the block is disabled.

Top module: `psc_modulator`

## Requirements
- R1: While `rst_n` is low, and one clock edge after any edge where `en` is low, every `gate_hi_*`, `gate_lo_*` and `level_*` output is 0.
- R2: With H the active half-period, each carrier count moves by exactly one per enabled edge between 0 and H. It turns around at both ends, so the triangle lasts 2H edges, with H edges rising and H falling.
- R3: On each disabled edge, carrier k (0-based) is loaded to triangle position p = floor(2H·k/N_CELLS). The count becomes p when p ≤ H and 2H−p otherwise, and the carrier rises only when p < H. With two cells, carrier 0 starts at 0 rising and carrier 1 starts at H falling.
- R4: A carrier's signed value is 2·count − H, on the same scale as the reference, where ±H means ±1. On each enabled edge, the upper gate of a cell (bit k of `gate_hi_*` for carrier k) is set to 1 if the held reference is above the carrier's current value, and to 0 if it is below.
- R5: When the held reference equals the carrier value, the cell's gate outputs keep their previous values.
- R6: After any enabled edge, `gate_lo` bit k is the inverse of `gate_hi` bit k. Both bits are never high at once.
- R7: `level_*` equals the number of ones in the same phase's `gate_hi_*`, updated on the same edge. Its range is 0 to N_CELLS.
- R8: `ref_ready` equals `en`. A reference triple is captured on an edge where `ref_valid` and `ref_ready` are both high, and it is first compared on the next edge. Without a handshake, reference input changes have no effect on the gates.
- R9: `half_period` is captured only on disabled edges. A change while enabled has no effect until `en` has been low for at least one edge.
- R10: A `half_period` of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Modulation enable; low forces gates off and reloads carriers |
| ref_valid | input | 1 | Reference triple valid |
| ref_ready | output | 1 | Reference triple accepted (equals `en`) |
| ref_u | input | REF_W | Phase U reference, signed |
| ref_v | input | REF_W | Phase V reference, signed |
| ref_w | input | REF_W | Phase W reference, signed |
| half_period | input | REF_W-1 | Carrier half-period H in clock cycles |
| gate_hi_u | output | N_CELLS | Phase U upper switch commands, bit k = cell k |
| gate_lo_u | output | N_CELLS | Phase U lower switch commands |
| gate_hi_v | output | N_CELLS | Phase V upper switch commands |
| gate_lo_v | output | N_CELLS | Phase V lower switch commands |
| gate_hi_w | output | N_CELLS | Phase W upper switch commands |
| gate_lo_w | output | N_CELLS | Phase W lower switch commands |
| level_u | output | clog2(N_CELLS+1) | Phase U count of upper switches on |
| level_v | output | clog2(N_CELLS+1) | Phase V count of upper switches on |
| level_w | output | clog2(N_CELLS+1) | Phase W count of upper switches on |

## Verification
On a single edge, a reference handshake and the comparison that uses the held reference can happen together. The new triple must not affect that edge's gates, only the following one. The bench provokes this by asserting `ref_valid` with new values while carriers run, then compares every gate and level output after each edge against an independent cycle model. The same applies at a carrier turnaround, where the reference can equal the peak value: the bench sets H=2 with a zero reference so that ties recur, and judges that the gates hold through them.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int N_PHASES = 3;
  typedef enum logic { RAMP_UP = 1'b0, RAMP_DOWN = 1'b1 } ramp_e;
endpackage

// File: rtl/psc_carrier.sv
module psc_carrier
  import psc_pkg::*;
#(
  parameter int CNT_W   = 11,
  parameter int N_CELLS = 2,
  parameter int IDX     = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] hp,
  output logic [CNT_W:0]   carrier
);
  localparam int PW = CNT_W + 2 + $clog2(N_CELLS + 1);

  logic [CNT_W-1:0] cnt, start_cnt, nxt;
  ramp_e            dir, start_dir;
  logic [PW-1:0]    two_h, pos;

  // starting point of this carrier within one triangle
  always_comb begin
    two_h = PW'(hp) << 1;
    pos   = (two_h * PW'(IDX)) / PW'(N_CELLS);
    if (pos <= PW'(hp)) begin
      start_cnt = CNT_W'(pos);
      start_dir = (pos < PW'(hp)) ? RAMP_UP : RAMP_DOWN;
    end else begin
      start_cnt = CNT_W'(two_h - pos);
      start_dir = RAMP_DOWN;
    end
    nxt = (dir == RAMP_UP) ? cnt + 1'b1 : cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      dir <= RAMP_UP;
    end else if (!run) begin
      cnt <= start_cnt;
      dir <= start_dir;
    end else begin
      cnt <= nxt;
      if (nxt == hp)        dir <= RAMP_DOWN;
      else if (nxt == '0)   dir <= RAMP_UP;
    end
  end

  // signed carrier on the reference scale: 2*cnt - hp
  assign carrier = ({1'b0, cnt} << 1) - {1'b0, hp};

  p_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (cnt <= $past(hp)))
    else $error("carrier exceeded half-period");

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> ((cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1)))
    else $error("carrier did not move by one");
endmodule

// File: rtl/psc_cell.sv
module psc_cell #(
  parameter int REF_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic signed [REF_W-1:0] ref_in,
  input  logic signed [REF_W-1:0] car,
  output logic                    fc_nxt,
  output logic                    gate_hi,
  output logic                    gate_lo
);
  always_comb begin
    if (ref_in > car)       fc_nxt = 1'b1;
    else if (ref_in < car)  fc_nxt = 1'b0;
    else                    fc_nxt = gate_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
    end else if (!run) begin
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
    end else begin
      gate_hi <= fc_nxt;
      gate_lo <= ~fc_nxt;
    end
  end

  p_never_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo))
    else $error("both switches of a cell on");

  p_complement_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (gate_hi != gate_lo))
    else $error("cell switches not complementary");

  p_above_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (ref_in > car)) |=> gate_hi)
    else $error("reference above carrier but gate off");

  p_below_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (ref_in < car)) |=> !gate_hi)
    else $error("reference below carrier but gate on");

  p_tie_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (ref_in == car)) |=> (gate_hi == $past(gate_hi)))
    else $error("gate moved on a tie");
endmodule

// File: rtl/psc_arm.sv
module psc_arm #(
  parameter  int REF_W   = 12,
  parameter  int N_CELLS = 2,
  localparam int LVL_W   = $clog2(N_CELLS + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          run,
  input  logic signed [REF_W-1:0]       ref_in,
  input  logic [N_CELLS-1:0][REF_W-1:0] carriers,
  output logic [N_CELLS-1:0]            gate_hi,
  output logic [N_CELLS-1:0]            gate_lo,
  output logic [LVL_W-1:0]              level
);
  logic [N_CELLS-1:0] fc_nxt;
  logic [LVL_W-1:0]   ones;

  for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
    psc_cell #(.REF_W(REF_W)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .ref_in  (ref_in),
      .car     ($signed(carriers[k])),
      .fc_nxt  (fc_nxt[k]),
      .gate_hi (gate_hi[k]),
      .gate_lo (gate_lo[k])
    );
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < N_CELLS; i++) ones = ones + LVL_W'(fc_nxt[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     level <= '0;
    else if (!run)  level <= '0;
    else            level <= ones;
  end

  p_level_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    level == LVL_W'($countones(gate_hi)))
    else $error("level disagrees with upper gates");
endmodule

// File: rtl/psc_modulator.sv
module psc_modulator
  import psc_pkg::*;
#(
  parameter  int REF_W   = 12,
  parameter  int N_CELLS = 2,
  localparam int CNT_W   = REF_W - 1,
  localparam int LVL_W   = $clog2(N_CELLS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    ref_valid,
  output logic                    ref_ready,
  input  logic signed [REF_W-1:0] ref_u,
  input  logic signed [REF_W-1:0] ref_v,
  input  logic signed [REF_W-1:0] ref_w,
  input  logic [CNT_W-1:0]        half_period,
  output logic [N_CELLS-1:0]      gate_hi_u,
  output logic [N_CELLS-1:0]      gate_lo_u,
  output logic [N_CELLS-1:0]      gate_hi_v,
  output logic [N_CELLS-1:0]      gate_lo_v,
  output logic [N_CELLS-1:0]      gate_hi_w,
  output logic [N_CELLS-1:0]      gate_lo_w,
  output logic [LVL_W-1:0]        level_u,
  output logic [LVL_W-1:0]        level_v,
  output logic [LVL_W-1:0]        level_w
);
  logic signed [REF_W-1:0]       ref_in   [N_PHASES];
  logic signed [REF_W-1:0]       ref_hold [N_PHASES];
  logic [N_CELLS-1:0]            hi_arr   [N_PHASES];
  logic [N_CELLS-1:0]            lo_arr   [N_PHASES];
  logic [LVL_W-1:0]              lvl_arr  [N_PHASES];
  logic [N_CELLS-1:0][REF_W-1:0] car_bus;
  logic [CNT_W-1:0]              hp_clamp, hp_q, hp_eff;
  logic                          take;

  assign ref_ready = en;
  assign take      = ref_valid & ref_ready;
  assign ref_in[0] = ref_u;
  assign ref_in[1] = ref_v;
  assign ref_in[2] = ref_w;

  // half-period: zero promoted to one, frozen while running
  assign hp_clamp = (half_period == '0) ? CNT_W'(1) : half_period;
  assign hp_eff   = en ? hp_q : hp_clamp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hp_q <= CNT_W'(1);
    else if (!en) hp_q <= hp_clamp;
  end

  for (genvar p = 0; p < N_PHASES; p++) begin : g_ref
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ref_hold[p] <= '0;
      else if (take)  ref_hold[p] <= ref_in[p];
    end
  end

  for (genvar k = 0; k < N_CELLS; k++) begin : g_car
    psc_carrier #(.CNT_W(CNT_W), .N_CELLS(N_CELLS), .IDX(k)) u_car (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (en),
      .hp      (hp_eff),
      .carrier (car_bus[k])
    );
  end

  for (genvar p = 0; p < N_PHASES; p++) begin : g_arm
    psc_arm #(.REF_W(REF_W), .N_CELLS(N_CELLS)) u_arm (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (en),
      .ref_in   (ref_hold[p]),
      .carriers (car_bus),
      .gate_hi  (hi_arr[p]),
      .gate_lo  (lo_arr[p]),
      .level    (lvl_arr[p])
    );
  end

  assign gate_hi_u = hi_arr[0];
  assign gate_lo_u = lo_arr[0];
  assign gate_hi_v = hi_arr[1];
  assign gate_lo_v = lo_arr[1];
  assign gate_hi_w = hi_arr[2];
  assign gate_lo_w = lo_arr[2];
  assign level_u   = lvl_arr[0];
  assign level_v   = lvl_arr[1];
  assign level_w   = lvl_arr[2];

  p_idle_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ((gate_hi_u | gate_lo_u | gate_hi_v | gate_lo_v | gate_hi_w | gate_lo_w) == '0
             && level_u == '0 && level_v == '0 && level_w == '0))
    else $error("outputs active while disabled");

  p_ref_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(ref_hold[0]) && $stable(ref_hold[1]) && $stable(ref_hold[2])))
    else $error("reference changed without handshake");

  p_hp_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(hp_q))
    else $error("half-period changed while running");

  p_hp_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hp_q != '0)
    else $error("zero half-period in use");
endmodule

// File: tb/psc_modulator_tb.sv
`timescale 1ns/1ps
module psc_modulator_tb;
  localparam int REF_W = 12;
  localparam int N     = 2;
  localparam int CNT_W = REF_W - 1;
  localparam int LVL_W = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic ref_valid = 1'b0;
  logic ref_ready;
  logic signed [REF_W-1:0] ref_u = '0, ref_v = '0, ref_w = '0;
  logic [CNT_W-1:0] half_period = CNT_W'(4);
  logic [N-1:0] gate_hi_u, gate_lo_u, gate_hi_v, gate_lo_v, gate_hi_w, gate_lo_w;
  logic [LVL_W-1:0] level_u, level_v, level_w;

  int n_checks = 0;
  int n_fail   = 0;

  // independent cycle model
  int mc [N];
  bit mup [N];
  int mH = 1;
  int mref [3];
  bit mfc [3][N];
  bit saw_full = 0, saw_zero = 0;

  always #4 clk = ~clk;

  psc_modulator #(.REF_W(REF_W), .N_CELLS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .ref_valid(ref_valid), .ref_ready(ref_ready),
    .ref_u(ref_u), .ref_v(ref_v), .ref_w(ref_w), .half_period(half_period),
    .gate_hi_u(gate_hi_u), .gate_lo_u(gate_lo_u), .gate_hi_v(gate_hi_v),
    .gate_lo_v(gate_lo_v), .gate_hi_w(gate_hi_w), .gate_lo_w(gate_lo_w),
    .level_u(level_u), .level_v(level_v), .level_w(level_w)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int pack_hi(int p);
    int v = 0;
    for (int k = 0; k < N; k++) if (mfc[p][k]) v |= (1 << k);
    return v;
  endfunction

  // one clock edge: predict, advance, compare at the next falling edge
  task automatic tick(input string tag);
    int exp_hi [3];
    int exp_lo [3];
    int exp_lv [3];
    bit on = en;
    if (!on) begin
      mH = (half_period == 0) ? 1 : int'(half_period);
      for (int k = 0; k < N; k++) begin
        int pos = (2 * mH * k) / N;
        mc[k]  = (pos <= mH) ? pos : 2 * mH - pos;
        mup[k] = (pos < mH);
      end
      for (int p = 0; p < 3; p++) for (int k = 0; k < N; k++) mfc[p][k] = 0;
      for (int p = 0; p < 3; p++) begin exp_hi[p] = 0; exp_lo[p] = 0; exp_lv[p] = 0; end
    end else begin
      for (int p = 0; p < 3; p++) begin
        exp_lv[p] = 0;
        for (int k = 0; k < N; k++) begin
          int car = 2 * mc[k] - mH;
          if (mref[p] > car) mfc[p][k] = 1;
          else if (mref[p] < car) mfc[p][k] = 0;
          exp_lv[p] += mfc[p][k];
        end
        exp_hi[p] = pack_hi(p);
        exp_lo[p] = (~exp_hi[p]) & ((1 << N) - 1);
      end
      for (int k = 0; k < N; k++) begin
        int nx = mup[k] ? mc[k] + 1 : mc[k] - 1;
        mc[k] = nx;
        if (nx == mH) mup[k] = 0;
        else if (nx == 0) mup[k] = 1;
      end
      if (ref_valid) begin
        mref[0] = int'(ref_u); mref[1] = int'(ref_v); mref[2] = int'(ref_w);
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(int'(gate_hi_u) == exp_hi[0], {tag, " gate_hi_u"}, gate_hi_u, exp_hi[0]);
    chk(int'(gate_lo_u) == exp_lo[0], {tag, " R6 gate_lo_u"}, gate_lo_u, exp_lo[0]);
    chk(int'(gate_hi_v) == exp_hi[1], {tag, " gate_hi_v"}, gate_hi_v, exp_hi[1]);
    chk(int'(gate_lo_v) == exp_lo[1], {tag, " R6 gate_lo_v"}, gate_lo_v, exp_lo[1]);
    chk(int'(gate_hi_w) == exp_hi[2], {tag, " gate_hi_w"}, gate_hi_w, exp_hi[2]);
    chk(int'(gate_lo_w) == exp_lo[2], {tag, " R6 gate_lo_w"}, gate_lo_w, exp_lo[2]);
    chk(int'(level_u) == exp_lv[0], {tag, " R7 level_u"}, level_u, exp_lv[0]);
    chk(int'(level_v) == exp_lv[1], {tag, " R7 level_v"}, level_v, exp_lv[1]);
    chk(int'(level_w) == exp_lv[2], {tag, " R7 level_w"}, level_w, exp_lv[2]);
    if (level_u == LVL_W'(N)) saw_full = 1;
    if (on && level_v == '0) saw_zero = 1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b0;
    repeat (3) @(negedge clk);
    chk(gate_hi_u == '0 && gate_lo_u == '0 && gate_hi_v == '0 && gate_lo_w == '0,
        "R1 reset gates", gate_hi_u, 0);
    chk(level_u == '0 && level_w == '0, "R1 reset level", level_u, 0);
    chk(ref_ready == 1'b0, "R8 ready low while disabled", ref_ready, 0);
    rst_n = 1'b1;
    for (int p = 0; p < 3; p++) mref[p] = 0;
    tick("R1 idle");
  endtask

  task automatic t_phase_shift();
    half_period = CNT_W'(4);
    tick("R3 load");
    en = 1'b1;
    tick("R3 first");
    // carrier 0 at -4 below ref 0, carrier 1 at +4 above it
    chk(gate_hi_u == 2'b01, "R3 opposite start", gate_hi_u, 1);
    chk(ref_ready == 1'b1, "R8 ready follows enable", ref_ready, 1);
    for (int i = 0; i < 16; i++) tick("R2 R4 triangle");
  endtask

  task automatic t_patterns();
    ref_valid = 1'b1; ref_u = 12'sd3; ref_v = -12'sd3; ref_w = 12'sd1;
    tick("R8 capture with compare");
    ref_valid = 1'b0;
    for (int i = 0; i < 16; i++) tick("R4 mixed refs");
    chk(saw_full, "R7 all upper switches on reached", saw_full, 1);
    chk(saw_zero, "R7 no upper switch on reached", saw_zero, 1);
    ref_valid = 1'b1; ref_u = 12'sd2047; ref_v = -12'sd2047; ref_w = -12'sd4;
    tick("R4 extreme capture");
    ref_valid = 1'b0;
    for (int i = 0; i < 10; i++) tick("R4 R5 extremes");
  endtask

  task automatic t_tie();
    en = 1'b0; half_period = CNT_W'(2);
    tick("R1 disable");
    en = 1'b1; ref_valid = 1'b1; ref_u = '0; ref_v = 12'sd2; ref_w = -12'sd2;
    tick("R8 capture");
    ref_valid = 1'b0;
    for (int i = 0; i < 12; i++) tick("R5 ties");
  endtask

  task automatic t_no_handshake();
    ref_u = 12'sd900; ref_v = -12'sd900; ref_w = 12'sd5;
    for (int i = 0; i < 8; i++) tick("R8 ignored without valid");
  endtask

  task automatic t_period_freeze();
    half_period = CNT_W'(7);
    for (int i = 0; i < 10; i++) tick("R9 change while enabled");
    en = 1'b0;
    tick("R9 reload");
    en = 1'b1;
    ref_valid = 1'b1; ref_u = 12'sd3; ref_v = -12'sd6; ref_w = '0;
    tick("R9 capture");
    ref_valid = 1'b0;
    for (int i = 0; i < 30; i++) tick("R9 new period");
  endtask

  task automatic t_zero_period();
    en = 1'b0; half_period = '0;
    tick("R10 load");
    en = 1'b1;
    ref_valid = 1'b1; ref_u = '0; ref_v = 12'sd1; ref_w = -12'sd1;
    tick("R10 capture");
    ref_valid = 1'b0;
    for (int i = 0; i < 8; i++) tick("R10 unit period");
  endtask

  task automatic t_disable_midrun();
    en = 1'b0;
    tick("R1 disable midrun");
    chk(gate_hi_u == '0 && gate_lo_u == '0 && level_u == '0, "R1 outputs off", gate_lo_u, 0);
  endtask

  initial begin
    #(8ns * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_phase_shift();
    t_patterns();
    t_tie();
    t_no_handshake();
    t_period_freeze();
    t_zero_period();
    t_disable_midrun();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule